// File: doc/BRIEF.md
# Programmable Serial Test Pattern Generator

This block produces a serial bit stream, one bit per enabled clock, for exercising and checking digital transmission equipment. It has two pattern sources. The pseudorandom source is a shift register whose active length (1 to 32 bits) and feedback tap mask can be set at run time. The repeating source rotates a loaded word of 1 to 32 bits. A hold input freezes the generator so that gapped-clock channels can be served from the same clock. Bit errors can be forced onto the line in two ways: a single error on request, or continuously at a decade rate from one per ten bits to one per ten million bits.

Software configures the block through a small write port. Writes to mode, length, tap mask and seed are staged, and a load strobe applies them and restarts the pattern from its first bit. A preset write fills the length and tap mask with one of seven maximal-length polynomials. Rate and single-error writes act at once.

Top module: `patgen_top`

## Requirements
- R1: In pseudorandom mode with length L (address 1 holds L-1 in bits 4:0) and tap mask M (address 2, bit k-1 set for tap k), the first bit after a load is bit L-1 of the seed. After each enabled bit the register shifts left, bits at L and above are cleared, and the new bit 0 is the XOR of all register bits selected by M within L.
- R2: A write to address 6 with index 0 to 6 in bits 2:0 sets the staged length and mask to one of seven polynomials. The indices give taps {6,5}, {9,5}, {11,9}, {15,14}, {20,3}, {23,18} and {32,22,2,1}, with periods 2^6-1, 2^9-1, 2^11-1, 2^15-1, 2^20-1, 2^23-1 and 2^32-1. Index 7 changes nothing.
- R3: In pseudorandom mode, a seed (address 3) whose low L bits are all zero is replaced at load by the value 1.
- R4: In repeating mode (address 0 bit 0 = 1), the low L bits of the loaded word are sent repeatedly, bit L-1 first, for any L from 1 to 32.
- R5: While tx_hold is high, tx_out keeps its value and the pattern does not advance. No bit is consumed.
- R6: A write to address 5 inverts exactly one bit: the first enabled bit after the write. The following bits are those of the undisturbed sequence.
- R7: A rate code n (address 4, bits 2:0) from 1 to 7 inverts every 10^n-th enabled bit. Counting starts at the rate write or the last load, and held cycles do not count. Code 0 inserts no errors. Inversions never alter the pattern state.
- R8: Writes to addresses 0 to 3 and 6 do not change the running stream until load is pulsed. Load restarts the stream from its first bit.
- R9: After reset, tx_out is 0, and the stream is the 2^6-1 sequence (taps 6 and 5) seeded with 1 and with no errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | W | Register write data |
| load | input | 1 | Apply staged configuration and restart pattern |
| tx_hold | input | 1 | Freeze generator for a gapped clock |
| tx_out | output | 1 | Registered serial test bit |

## Verification
A corrupted shift state or a wrong feedback tap shows up on tx_out within a few bits of the fault, because every bit is compared against an independent model. A register stuck short of maximal length changes the ones count over a full period, and the sweep checks that count for the 6, 9, 11 and 15 bit presets. A mistimed error counter shows an inversion at the wrong bit index within one rate period. A hold leak shows as a changed output during a held cycle, or as the stream running one bit ahead once the hold ends.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  typedef enum logic [2:0] {
    A_MODE   = 3'd0,
    A_LEN    = 3'd1,
    A_MASK   = 3'd2,
    A_SEED   = 3'd3,
    A_RATE   = 3'd4,
    A_ONCE   = 3'd5,
    A_PRESET = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;

  localparam int NPRESET = 7;

  function automatic int preset_len(input int idx);
    case (idx)
      0: return 6;
      1: return 9;
      2: return 11;
      3: return 15;
      4: return 20;
      5: return 23;
      default: return 32;
    endcase
  endfunction

  // bit k-1 set for feedback tap k
  function automatic logic [31:0] preset_mask(input int idx);
    case (idx)
      0: return 32'h0000_0030;
      1: return 32'h0000_0110;
      2: return 32'h0000_0500;
      3: return 32'h0000_6000;
      4: return 32'h0008_0004;
      5: return 32'h0042_0000;
      default: return 32'h8020_0003;
    endcase
  endfunction

  function automatic longint pow10(input int n);
    longint v;
    v = 1;
    for (int i = 0; i < n; i++) v = v * 10;
    return v;
  endfunction

endpackage

// File: rtl/patgen_regs.sv
module patgen_regs
  import patgen_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = $clog2(W),
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic          cfg_rep,
  output logic [LW-1:0] cfg_lenm1,
  output logic [W-1:0]  cfg_mask,
  output logic [W-1:0]  cfg_seed,
  output logic [RW-1:0] rate_code,
  output logic          rate_wr,
  output logic          once_req
);

  logic [31:0] pmask;
  int          pidx;

  always_comb begin
    pidx  = int'(wdata[2:0]);
    pmask = preset_mask(pidx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rep   <= 1'b0;
      cfg_lenm1 <= LW'(preset_len(0) - 1);
      cfg_mask  <= W'(preset_mask(0));
      cfg_seed  <= W'(1);
      rate_code <= '0;
    end else if (we) begin
      case (addr)
        A_MODE: cfg_rep   <= wdata[0];
        A_LEN:  cfg_lenm1 <= wdata[LW-1:0];
        A_MASK: cfg_mask  <= wdata;
        A_SEED: cfg_seed  <= wdata;
        A_RATE: rate_code <= wdata[RW-1:0];
        A_PRESET: begin
          if (pidx < NPRESET) begin
            cfg_lenm1 <= LW'(preset_len(pidx) - 1);
            cfg_mask  <= W'(pmask);
          end
        end
        default: ;
      endcase
    end
  end

  assign rate_wr  = we && (addr == A_RATE);
  assign once_req = we && (addr == A_ONCE);

  // R2: index 7 leaves the staged length untouched
  p_preset_idx7_r2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_PRESET && wdata[2:0] == 3'd7) |=> $stable(cfg_lenm1));

endmodule

// File: rtl/patgen_shifter.sv
module patgen_shifter #(
  parameter int W  = 32,
  parameter int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic          cfg_rep,
  input  logic [LW-1:0] cfg_lenm1,
  input  logic [W-1:0]  cfg_mask,
  input  logic [W-1:0]  cfg_seed,
  output logic          cur_bit
);

  logic          act_rep;
  logic [LW-1:0] act_lenm1;
  logic [W-1:0]  act_mask;
  logic [W-1:0]  state;
  logic [W-1:0]  act_lm, cfg_lm, seed_m, fb_sel;
  logic          fb;

  function automatic logic [W-1:0] len_mask(input logic [LW-1:0] lm1);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (LW'(i) <= lm1);
    return m;
  endfunction

  always_comb begin
    act_lm  = len_mask(act_lenm1);
    cfg_lm  = len_mask(cfg_lenm1);
    cur_bit = state[act_lenm1];
    fb_sel  = act_rep ? (W'(1) << act_lenm1) : (act_mask & act_lm);
    fb      = ^(state & fb_sel);
    seed_m  = cfg_seed & cfg_lm;
    if (!cfg_rep && seed_m == '0) seed_m = W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_rep   <= 1'b0;
      act_lenm1 <= LW'(5);
      act_mask  <= W'(32'h30);
      state     <= W'(1);
    end else if (load) begin
      act_rep   <= cfg_rep;
      act_lenm1 <= cfg_lenm1;
      act_mask  <= cfg_mask;
      state     <= seed_m;
    end else if (adv) begin
      state <= ((state << 1) | W'(fb)) & act_lm;
    end
  end

  // R3: a pseudorandom register never sits at all zeros
  p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    !act_rep |-> ((state & act_lm) != '0));

  // R1: bits above the active length stay clear
  p_len_clear_r1: assert property (@(posedge clk) disable iff (rst)
    ((state & ~act_lm) == '0));

  // R5: no advance, no load -> state frozen
  p_state_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(state));

endmodule

// File: rtl/patgen_errins.sv
module patgen_errins
  import patgen_pkg::*;
#(
  parameter int RW = 3,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          adv,
  input  logic [RW-1:0] rate_code,
  input  logic          once_req,
  output logic          inject
);

  logic [CW-1:0] cnt, limit_m1;
  logic          pending, rate_hit;

  always_comb begin
    limit_m1 = CW'(pow10(int'(rate_code)) - 1);
    rate_hit = (rate_code != '0) && (cnt == limit_m1);
    inject   = adv && (pending || rate_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (restart)                       cnt <= '0;
      else if (adv && rate_code != '0)   cnt <= rate_hit ? '0 : cnt + 1'b1;
      if (once_req)                      pending <= 1'b1;
      else if (adv)                      pending <= 1'b0;
    end
  end

  // R7: bit counter never passes the decade limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (rate_code != '0) |-> (cnt <= limit_m1));

  // R6: one enabled bit consumes the single-error request
  p_once_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (pending && adv && !once_req) |=> !pending);

  // R7: held cycles do not count
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!adv && !restart) |=> $stable(cnt));

endmodule

// File: rtl/patgen_top.sv
module patgen_top
  import patgen_pkg::*;
#(
  parameter int W        = 32,
  parameter int RATE_MAX = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         load,
  input  logic         tx_hold,
  output logic         tx_out
);

  localparam int LW = $clog2(W);
  localparam int RW = $clog2(RATE_MAX + 1);
  localparam int CW = $clog2(pow10(RATE_MAX));

  logic          cfg_rep, rate_wr, once_req, cur_bit, inject, adv;
  logic [LW-1:0] cfg_lenm1;
  logic [W-1:0]  cfg_mask, cfg_seed;
  logic [RW-1:0] rate_code;

  assign adv = !tx_hold && !load;

  patgen_regs #(.W(W), .LW(LW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg_rep(cfg_rep), .cfg_lenm1(cfg_lenm1), .cfg_mask(cfg_mask),
    .cfg_seed(cfg_seed), .rate_code(rate_code), .rate_wr(rate_wr),
    .once_req(once_req)
  );

  patgen_shifter #(.W(W), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .cfg_rep(cfg_rep),
    .cfg_lenm1(cfg_lenm1), .cfg_mask(cfg_mask), .cfg_seed(cfg_seed),
    .cur_bit(cur_bit)
  );

  patgen_errins #(.RW(RW), .CW(CW)) u_err (
    .clk(clk), .rst(rst), .restart(rate_wr || load), .adv(adv),
    .rate_code(rate_code), .once_req(once_req), .inject(inject)
  );

  always_ff @(posedge clk) begin
    if (rst)      tx_out <= 1'b0;
    else if (adv) tx_out <= cur_bit ^ inject;
  end

  // R5: held or loading cycles leave the line unchanged
  p_hold_out_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_hold || load) |=> $stable(tx_out));

endmodule

// File: tb/tb_patgen_top.sv
module tb_patgen_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        load = 1'b0;
  logic        tx_hold = 1'b1;
  logic        tx_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  patgen_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .load(load), .tx_hold(tx_hold), .tx_out(tx_out)
  );

  always #5 clk = ~clk;

  // bench model of the stream
  bit          m_rep;
  int          m_len;
  logic [31:0] m_mask, m_state;
  logic        m_bit;

  function automatic logic [31:0] lmask(input int l);
    return (l == 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 1);
  endfunction

  task automatic model_load(input bit rep, input int l, input logic [31:0] mask,
                            input logic [31:0] seed);
    m_rep = rep; m_len = l; m_mask = mask;
    m_state = seed & lmask(l);
    if (!rep && m_state == 0) m_state = 32'h1;
  endtask

  task automatic model_step();
    logic fbv;
    m_bit = m_state[m_len-1];
    fbv = m_rep ? m_bit : ^(m_state & m_mask & lmask(m_len));
    m_state = ((m_state << 1) | {31'b0, fbv}) & lmask(m_len);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tx_out=%0b expected %0b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    tx_hold = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic do_load();
    tx_hold = 1'b1; load = 1'b1;
    tick();
    load = 1'b0;
  endtask

  // one enabled bit, optionally inverted by an expected error
  task automatic step(input string req, input bit inv);
    tx_hold = 1'b0;
    tick();
    tx_hold = 1'b1;
    model_step();
    chk(req, tx_out, m_bit ^ inv);
  endtask

  task automatic setup(input bit rep, input int l, input logic [31:0] mask,
                       input logic [31:0] seed);
    wr(3'd0, {31'b0, rep});
    wr(3'd1, 32'(l - 1));
    wr(3'd2, mask);
    wr(3'd3, seed);
    do_load();
    model_load(rep, l, mask, seed);
  endtask

  int          p_len  [7] = '{6, 9, 11, 15, 20, 23, 32};
  logic [31:0] p_mask [7] = '{32'h30, 32'h110, 32'h500, 32'h6000,
                              32'h80004, 32'h420000, 32'h80200003};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ones;
    logic first, last;
    repeat (3) tick();
    chk("R9 reset", tx_out, 1'b0);
    rst = 1'b0;
    tick();
    chk("R9 idle after reset", tx_out, 1'b0);
    model_load(0, 6, 32'h30, 32'h1);
    for (int i = 0; i < 70; i++) step("R9 default stream", 0);

    // R2 and R1: presets, full-period ones count for the short ones
    for (int p = 0; p < 7; p++) begin
      wr(3'd0, 32'h0);
      wr(3'd3, 32'h1);
      wr(3'd6, 32'(p));
      do_load();
      model_load(0, p_len[p], p_mask[p], 32'h1);
      if (p_len[p] <= 15) begin
        ones = 0;
        for (int i = 0; i < (1 << p_len[p]) - 1; i++) begin
          step("R2 preset stream", 0);
          if (i == 0) first = tx_out;
          ones += int'(tx_out);
        end
        chk_int("R2 ones per period", ones, 1 << (p_len[p] - 1));
        step("R2 period wrap", 0);
        chk("R2 period repeats", tx_out, first);
      end else begin
        for (int i = 0; i < 300; i++) step("R2 long preset", 0);
      end
    end
    // R2: index 7 ignored, length stays at 32 bits
    wr(3'd6, 32'h7);
    do_load();
    model_load(0, 32, 32'h80200003, 32'h1);
    for (int i = 0; i < 64; i++) step("R2 index 7 ignored", 0);

    // R1: custom polynomial taps 5 and 3
    setup(0, 5, 32'h14, 32'h1B);
    ones = 0;
    for (int i = 0; i < 31; i++) begin
      step("R1 custom taps", 0);
      ones += int'(tx_out);
    end
    chk_int("R1 ones per period", ones, 16);

    // R3: zero seed
    setup(0, 9, 32'h110, 32'hFFFF_FE00);
    for (int i = 0; i < 20; i++) step("R3 zero seed forced", 0);

    // R4: repeating words
    setup(1, 1, 32'h0, 32'h1);
    for (int i = 0; i < 8; i++) step("R4 one-bit word", 0);
    setup(1, 5, 32'h0, 32'hFFFF_FFF6);
    for (int i = 0; i < 20; i++) begin
      tx_hold = 1'b0; tick(); tx_hold = 1'b1; model_step();
      chk("R4 five-bit word", tx_out, (5'b10110 >> (4 - (i % 5))) & 1'b1);
    end
    setup(1, 32, 32'h0, 32'hDEAD_BEEF);
    for (int i = 0; i < 70; i++) step("R4 32-bit word", 0);
    setup(1, 7, 32'h0, 32'h0);
    for (int i = 0; i < 14; i++) step("R4 zero word stays zero", 0);

    // R5: hold mid-stream
    setup(0, 11, 32'h500, 32'h5A5);
    for (int i = 0; i < 10; i++) step("R5 before hold", 0);
    last = tx_out;
    tx_hold = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R5 output frozen", tx_out, last);
    end
    for (int i = 0; i < 20; i++) step("R5 resumes without skip", 0);

    // R6: single error
    wr(3'd5, 32'h0);
    step("R6 first bit inverted", 1);
    for (int i = 0; i < 30; i++) step("R6 sequence undisturbed", 0);

    // R7: rate codes with interleaved holds
    for (int code = 1; code <= 3; code++) begin
      int n, per, en;
      per = (code == 1) ? 10 : (code == 2) ? 100 : 1000;
      n = 3 * per;
      wr(3'd4, 32'(code));
      en = 0;
      for (int i = 0; i < n; i++) begin
        if (i % 3 == 1) begin
          last = tx_out; tick();
          chk("R7 hold not counted", tx_out, last);
        end
        step("R7 decade rate", ((en % per) == per - 1));
        en++;
      end
    end
    wr(3'd4, 32'h0);
    for (int i = 0; i < 40; i++) step("R7 rate off", 0);

    // R8: staged writes without load do nothing
    setup(0, 6, 32'h30, 32'h2A);
    for (int i = 0; i < 5; i++) step("R8 before staging", 0);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'd3);
    wr(3'd3, 32'h9);
    wr(3'd6, 32'h3);
    for (int i = 0; i < 30; i++) step("R8 no effect before load", 0);
    do_load();
    model_load(1, 15, 32'h6000, 32'h9);
    for (int i = 0; i < 40; i++) step("R8 restart after load", 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule